// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches a small general-purpose input port and raises one change flag when any enabled pin differs from a reference copy of the port. The reference copy is not refreshed every clock. It is taken only when the port is read or written. Between those accesses, a pin that moves away from its captured value keeps the flag asserted. Software acknowledges the event by accessing the port first, which makes the reference equal to the pins again. It then clears the flag. A clear issued while a difference is still pending is overridden by the next set.

The pins pass through a two-flop synchronizer before any comparison. The reference copy is taken from the synchronized values. Each pin has its own enable bit, and a per-pin analog-select input removes that pin from the comparison. A set flag also drives a wake request.

There are two resets. The power-on reset clears the enables and the flag, and loads the reference from the pins. The warm reset clears only the flag: the reference and the enables are kept, so a difference that was pending before the warm reset sets the flag again once that reset ends.

Top module: `port_change_detect`

## Requirements
- R1: After power-on reset all enable bits are 0. While every enable bit is 0, no pin activity sets `chg_flag`, and `chg_flag` and `wake_req` are 0 after reset.
- R2: A pin whose enable bit (bit i of `en_wdata`, written with `en_we`) is 0 never contributes to `chg_flag`.
- R3: When an enabled pin's synchronized value differs from its reference bit, `chg_flag` and `wake_req` become 1 on the third rising edge after the pin changes, and not earlier.
- R4: The per-pin differences are ORed: a difference on any single enabled pin, the lowest (bit 0) or the highest (bit 5), sets the flag.
- R5: While a difference persists, `flag_clr` has no lasting effect, because the set has priority over the clear and `chg_flag` stays 1.
- R6: A cycle with `rd_stb` high loads the reference from the synchronized pins at that edge. After that, a `flag_clr` cycle clears `chg_flag` to 0.
- R7: A cycle with `wr_stb` high reloads the reference in the same way as a read.
- R8: `warm_rst_n` low clears `chg_flag` and `wake_req` and leaves the reference and the enables unchanged. If a difference exists when the warm reset ends, the flag is set on the first rising edge after its release.
- R9: A pin whose `analog_sel` bit is 1 is excluded from the comparison whatever its enable bit is, and reads as 0 on `rd_data`.
- R10: `rd_data` shows the synchronized digital pin values two rising edges after a pin change.
- R11: On power-on reset the reference is loaded from the synchronized pins, so pins that are nonzero and stable through reset give no flag once they are enabled.
- R12: A pin change that reaches the synchronizer output on the same edge as a read may be taken into the reference and give no flag. Either outcome is allowed, and after a further read and clear the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| warm_rst_n | input | 1 | Warm reset, active low; clears only the flag |
| pin_i | input | 6 | Asynchronous port pins |
| analog_sel | input | 6 | 1 marks a pin as analog: no comparison, reads 0 |
| rd_stb | input | 1 | Port read strobe; reloads the reference |
| wr_stb | input | 1 | Port write strobe; reloads the reference |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | New per-pin enable bits |
| flag_clr | input | 1 | Flag clear strobe |
| chg_flag | output | 1 | Port change flag |
| wake_req | output | 1 | Wake request, asserted while the flag is set |
| rd_data | output | 6 | Synchronized pin values for a port read |

## Verification
A pin change reaches `rd_data` two rising edges later and `chg_flag` three edges later. The reference update from a read or write strobe, the result of a clear, and an enable write each take effect on the edge that ends the strobe cycle. A flag that re-arms after warm reset shows on the first edge after release. The bench drives every input on a falling edge and counts the rising edges each result needs before it samples on a later falling edge. For the flag it also checks one edge early that the flag is still 0. For the read-race case it accepts either value in the race cycle and checks only the state that follows a further read and clear.

// File: rtl/pce_pkg.sv
package pce_pkg;
   typedef enum logic [1:0] {
      FLG_HOLD = 2'd0,
      FLG_SET  = 2'd1,
      FLG_CLR  = 2'd2
   } flg_act_e;

   localparam int unsigned PCE_MIN_SYNC = 2;
endpackage

// File: rtl/pce_sync.sv
module pce_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk) begin
      stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pce_track.sv
module pce_track #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             access,
   input  logic [WIDTH-1:0] sync_i,
   input  logic             en_we,
   input  logic [WIDTH-1:0] en_wdata,
   output logic [WIDTH-1:0] snap_o,
   output logic [WIDTH-1:0] en_o
);
   logic [WIDTH-1:0] snap_q;
   logic [WIDTH-1:0] en_q;

   // The reference has no warm reset. Power-on reset loads it from the pins.
   always_ff @(posedge clk) begin
      if (!por_n || access) snap_q <= sync_i;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   assign snap_o = snap_q;
   assign en_o   = en_q;
endmodule

// File: rtl/pce_flag.sv
module pce_flag
   import pce_pkg::*;
#(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic [WIDTH-1:0] snap_i,
   input  logic [WIDTH-1:0] en_i,
   input  logic [WIDTH-1:0] analog_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] mism_o,
   output logic             flag_o
);
   flg_act_e act;
   logic     flag_q;

   assign mism_o = (sync_i ^ snap_i) & en_i & ~analog_i;

   always_comb begin
      if (|mism_o)    act = FLG_SET;
      else if (clr_i) act = FLG_CLR;
      else            act = FLG_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else begin
         case (act)
            FLG_SET: flag_q <= 1'b1;
            FLG_CLR: flag_q <= 1'b0;
            default: flag_q <= flag_q;
         endcase
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/port_change_detect.sv
module port_change_detect #(
   parameter int unsigned PIN_W            = 6,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter bit          READ_ZERO_ANALOG = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             warm_rst_n,
   input  logic [PIN_W-1:0] pin_i,
   input  logic [PIN_W-1:0] analog_sel,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic             en_we,
   input  logic [PIN_W-1:0] en_wdata,
   input  logic             flag_clr,
   output logic             chg_flag,
   output logic             wake_req,
   output logic [PIN_W-1:0] rd_data
);
   localparam int unsigned MIN_SYNC = pce_pkg::PCE_MIN_SYNC;

   generate
      if (PIN_W < 1) begin : g_bad_width
         $error("PIN_W must be at least 1");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES below minimum");
      end
   endgenerate

   logic [PIN_W-1:0] sync_q;
   logic [PIN_W-1:0] snap_q;
   logic [PIN_W-1:0] en_q;
   logic [PIN_W-1:0] mism_vec;
   logic             flag_rst_n;
   logic             port_access;

   assign flag_rst_n  = por_n & warm_rst_n;
   assign port_access = rd_stb | wr_stb;

   pce_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d_i (pin_i),
      .q_o (sync_q)
   );

   pce_track #(.WIDTH(PIN_W)) u_track (
      .clk      (clk),
      .por_n    (por_n),
      .access   (port_access),
      .sync_i   (sync_q),
      .en_we    (en_we),
      .en_wdata (en_wdata),
      .snap_o   (snap_q),
      .en_o     (en_q)
   );

   pce_flag #(.WIDTH(PIN_W)) u_flag (
      .clk      (clk),
      .rst_n    (flag_rst_n),
      .sync_i   (sync_q),
      .snap_i   (snap_q),
      .en_i     (en_q),
      .analog_i (analog_sel),
      .clr_i    (flag_clr),
      .mism_o   (mism_vec),
      .flag_o   (chg_flag)
   );

   assign wake_req = chg_flag;

   generate
      if (READ_ZERO_ANALOG) begin : g_rd_mask
         assign rd_data = sync_q & ~analog_sel;
      end else begin : g_rd_raw
         assign rd_data = sync_q;
      end
   endgenerate
endmodule

// File: rtl/pce_chk.sv
module pce_chk #(
   parameter int unsigned PIN_W = 6
) (
   input logic             clk,
   input logic             por_n,
   input logic             warm_rst_n,
   input logic             rd_stb,
   input logic             wr_stb,
   input logic             flag_clr,
   input logic [PIN_W-1:0] sync_q,
   input logic [PIN_W-1:0] snap_q,
   input logic [PIN_W-1:0] en_q,
   input logic [PIN_W-1:0] mism_vec,
   input logic             chg_flag
);
   // R1
   en_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(por_n) |-> (en_q == '0));

   // R5
   mism_sets_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (|mism_vec) |=> chg_flag);

   // R6
   clr_sticks_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (chg_flag && flag_clr && (mism_vec == '0)) |=> !chg_flag);

   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (!chg_flag && (mism_vec == '0)) |=> !chg_flag);

   // R7
   snap_load_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rd_stb || wr_stb) |=> (snap_q == $past(sync_q)));

   // R8
   snap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(rd_stb || wr_stb) |=> $stable(snap_q));

   // R8
   warm_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      !warm_rst_n |-> !chg_flag);
endmodule

bind port_change_detect pce_chk #(.PIN_W(PIN_W)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .warm_rst_n (warm_rst_n),
   .rd_stb     (rd_stb),
   .wr_stb     (wr_stb),
   .flag_clr   (flag_clr),
   .sync_q     (sync_q),
   .snap_q     (snap_q),
   .en_q       (en_q),
   .mism_vec   (mism_vec),
   .chg_flag   (chg_flag)
);

// File: tb/tb_port_change_detect.sv
`timescale 1ns/1ps
module tb_port_change_detect;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       warm_rst_n = 1'b1;
   logic [5:0] pin_i = 6'h15;
   logic [5:0] analog_sel = '0;
   logic       rd_stb = 1'b0;
   logic       wr_stb = 1'b0;
   logic       en_we = 1'b0;
   logic [5:0] en_wdata = '0;
   logic       flag_clr = 1'b0;
   logic       chg_flag;
   logic       wake_req;
   logic [5:0] rd_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   port_change_detect dut (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .pin_i(pin_i),
      .analog_sel(analog_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .en_we(en_we), .en_wdata(en_wdata), .flag_clr(flag_clr),
      .chg_flag(chg_flag), .wake_req(wake_req), .rd_data(rd_data)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_read();
      rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
   endtask

   task automatic do_clear();
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
   endtask

   task automatic set_en(input logic [5:0] v);
      en_we = 1'b1; en_wdata = v; cyc(1); en_we = 1'b0;
   endtask

   task automatic t_reset_and_disabled();
      cyc(5);
      por_n = 1'b1;
      cyc(1);
      chk("R1 flag after reset", {5'd0, chg_flag}, 6'h0);
      chk("R1 wake after reset", {5'd0, wake_req}, 6'h0);
      chk("R10 rd_data after reset", rd_data, 6'h15);
      pin_i = 6'h2A;
      cyc(4);
      chk("R1 no flag with enables clear", {5'd0, chg_flag}, 6'h0);
      pin_i = 6'h15;
      cyc(3);
      set_en(6'h3F);
      cyc(3);
      chk("R11 reference loaded at power-on", {5'd0, chg_flag}, 6'h0);
   endtask

   task automatic t_change_latency();
      pin_i = 6'h14;
      cyc(2);
      chk("R10 rd_data two edges after change", rd_data, 6'h14);
      chk("R3 flag not yet set", {5'd0, chg_flag}, 6'h0);
      cyc(1);
      chk("R3 flag on third edge", {5'd0, chg_flag}, 6'h1);
      chk("R3 wake follows flag", {5'd0, wake_req}, 6'h1);
      do_read();
      do_clear();
      chk("R6 clear after read sticks", {5'd0, chg_flag}, 6'h0);
      pin_i = 6'h34;
      cyc(3);
      chk("R4 top pin sets flag", {5'd0, chg_flag}, 6'h1);
      do_read();
      do_clear();
      chk("R4 cleared after read", {5'd0, chg_flag}, 6'h0);
   endtask

   task automatic t_persist_and_write();
      pin_i = 6'h30;
      cyc(3);
      chk("R5 flag set", {5'd0, chg_flag}, 6'h1);
      do_clear();
      chk("R5 clear ignored while mismatch", {5'd0, chg_flag}, 6'h1);
      wr_stb = 1'b1; cyc(1); wr_stb = 1'b0;
      do_clear();
      chk("R7 write resync lets clear stick", {5'd0, chg_flag}, 6'h0);
   endtask

   task automatic t_disabled_pin();
      set_en(6'h01);
      pin_i = 6'h38;
      cyc(4);
      chk("R2 disabled pin ignored", {5'd0, chg_flag}, 6'h0);
      do_read();
   endtask

   task automatic t_analog();
      set_en(6'h3F);
      analog_sel = 6'h02;
      pin_i = 6'h3A;
      cyc(3);
      chk("R9 analog pin masked", {5'd0, chg_flag}, 6'h0);
      chk("R9 analog pin reads zero", rd_data, 6'h38);
      do_read();
      analog_sel = 6'h00;
      cyc(2);
      chk("R9 no flag after unmask", {5'd0, chg_flag}, 6'h0);
      chk("R10 rd_data unmasked", rd_data, 6'h3A);
   endtask

   task automatic t_warm();
      pin_i = 6'h3B;
      cyc(3);
      chk("R8 flag before warm reset", {5'd0, chg_flag}, 6'h1);
      warm_rst_n = 1'b0;
      cyc(1);
      chk("R8 flag cleared in warm reset", {5'd0, chg_flag}, 6'h0);
      chk("R8 wake cleared in warm reset", {5'd0, wake_req}, 6'h0);
      cyc(1);
      warm_rst_n = 1'b1;
      cyc(1);
      chk("R8 flag re-set after warm release", {5'd0, chg_flag}, 6'h1);
      do_read();
      do_clear();
      chk("R8 clear after resync", {5'd0, chg_flag}, 6'h0);
   endtask

   task automatic t_race();
      pin_i = 6'h33;
      cyc(1);
      rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
      tests++;
      if (chg_flag !== 1'b0 && chg_flag !== 1'b1) begin
         fails++;
         $display("FAIL R12 race flag unknown: actual %b expected 0 or 1", chg_flag);
      end
      cyc(1);
      do_read();
      do_clear();
      chk("R12 settled after read race", {5'd0, chg_flag}, 6'h0);
   endtask

   initial begin
      t_reset_and_disabled();
      t_change_latency();
      t_persist_and_write();
      t_disabled_pin();
      t_analog();
      t_warm();
      t_race();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule